// File: doc/BRIEF.md
# Interrupt Delegation and Take Unit

This unit sits beside the trap logic of a hart that has machine (M), supervisor (S) and user (U) privilege levels. Each cycle it looks at which interrupt sources are pending and enabled. It combines each source's delegation bit with the current privilege and with the global enables, and decides whether an interrupt may be taken and which mode receives it. When the core signals an instruction boundary and some interrupt is eligible, a take strobe rises on the next cycle. The strobe comes with the target mode and the bit index of the winning source.

The unit holds two registers: the software-writable pending bits and the interrupt-enable register. A small CSR-style port writes them through four views. Two are machine views: the full pending view and the full enable view. Two are supervisor views: the pending and enable views filtered by the delegation vector. Hardware pending sources and the delegation vector come in as inputs.

Privilege codes are U = 2'b00, S = 2'b01 and M = 2'b11 (2'b10 is treated as M). View select codes are 0 = machine pending, 1 = supervisor pending, 2 = machine enable and 3 = supervisor enable. Operation codes are 0 = write, 1 = set bits, 2 = clear bits and 3 = no effect.

Top module: `irq_delegation_unit`

## Requirements
- R1: During and right after reset, `takeIrq` is 0, `takeMode` is 2'b11, `takeCause` is 0, the software pending bits are 0 and the enable register is 0.
- R2: `mipView` equals (`hwPend` OR software pending) AND 12'hAAA. `sipView` equals `mipView` AND `deleg`.
- R3: `sieView` equals `mieView` AND `deleg`. A write through the supervisor enable view (select 3) changes only enable bits that are inside 12'hAAA and delegated.
- R4: A write through the machine pending view (select 0) changes only the software pending bits 1, 5 and 9. For example, a set with data 12'h020 makes the supervisor timer bit 5 pending. A write through the supervisor pending view (select 1) changes only bit 1, and only when `deleg[1]` is 1. Operation code 3 changes nothing.
- R5: An interrupt whose `deleg` bit is 1 is never taken while `privLvl` is M.
- R6: A pending, enabled interrupt whose `deleg` bit is 0 is taken with `takeMode` = 2'b11. In S or U it is always eligible; in M it is eligible only when `gieM` is 1.
- R7: A pending, enabled interrupt whose `deleg` bit is 1 is taken with `takeMode` = 2'b01. In U it is always eligible; in S it is eligible only when `gieS` is 1.
- R8: When several interrupts are eligible, M-targeted ones win over S-targeted ones. Within a target mode the order is bit 11, 3, 7, 9, 1, 5. `takeCause` is the bit index of the winner.
- R9: `takeIrq` is 1 in the cycle after an edge at which `instrBoundary` was 1 and some interrupt was eligible; otherwise it is 0. `takeMode` and `takeCause` hold their values between takes.
- R10: A write through the machine enable view (select 2) changes only enable bits inside 12'hAAA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| hwPend | input | 12 | Hardware pending sources |
| deleg | input | 12 | Delegation vector, 1 = handled in S |
| privLvl | input | 2 | Current privilege level |
| gieM | input | 1 | Machine global interrupt enable |
| gieS | input | 1 | Supervisor global interrupt enable |
| instrBoundary | input | 1 | Core is at an instruction boundary |
| csrWe | input | 1 | CSR write strobe |
| csrSel | input | 2 | View being written |
| csrOp | input | 2 | Write, set, clear or none |
| csrWdata | input | 12 | CSR write data |
| takeIrq | output | 1 | Take-interrupt strobe |
| takeMode | output | 2 | Target mode of the taken interrupt |
| takeCause | output | 4 | Bit index of the taken interrupt |
| mipView | output | 12 | Machine pending view |
| mieView | output | 12 | Machine enable view |
| sipView | output | 12 | Supervisor pending view |
| sieView | output | 12 | Supervisor enable view |

## Verification
A corrupted software pending or enable bit shows at the four views in the cycle after the write that caused it. A wrong delegation or privilege decision shows one cycle after a boundary. It appears either as a take strobe that should not have fired, or as a wrong target mode or cause; the M-mode case with a delegated supervisor timer interrupt is driven directly. Random traffic mixes privilege levels, delegation patterns and view writes, so priority and masking slips surface within a few boundaries.

// File: rtl/irq_deleg_pkg.sv
package irq_deleg_pkg;
  localparam int NUM_IRQ = 12;
  localparam int CAUSE_W = $clog2(NUM_IRQ);
  localparam logic [NUM_IRQ-1:0] IRQ_MASK  = 12'hAAA;
  localparam logic [NUM_IRQ-1:0] SW_MASK   = 12'h222;
  localparam logic [NUM_IRQ-1:0] SSIP_MASK = 12'h002;

  localparam logic [1:0] SEL_MIP = 2'd0;
  localparam logic [1:0] SEL_SIP = 2'd1;
  localparam logic [1:0] SEL_MIE = 2'd2;
  localparam logic [1:0] SEL_SIE = 2'd3;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } csrOp_e;

  typedef struct packed {
    logic               pendLoad;
    logic               enLoad;
    csrOp_e             op;
    logic [NUM_IRQ-1:0] pendMask;
    logic [NUM_IRQ-1:0] enMask;
  } wrStrobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_deleg_pkg::*;
#(
  parameter int N = NUM_IRQ,
  parameter logic [N-1:0] VALID_MASK = IRQ_MASK
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] hwPend,
  input  logic [N-1:0] deleg,
  input  logic [1:0]   privLvl,
  input  logic         gieM,
  input  logic         gieS,
  input  logic [N-1:0] csrWdata,
  input  wrStrobe_t    strobe,
  output logic [N-1:0] mipView,
  output logic [N-1:0] mieView,
  output logic [N-1:0] sipView,
  output logic [N-1:0] sieView,
  output logic [N-1:0] mElig,
  output logic [N-1:0] sElig
);
  logic [N-1:0] swPend;
  logic [N-1:0] enReg;
  logic [N-1:0] pendEn;
  logic         globalM;
  logic         globalS;

  function automatic logic [N-1:0] applyOp(logic [N-1:0] old, logic [N-1:0] wd,
                                           logic [N-1:0] mask, csrOp_e op);
    case (op)
      OP_WRITE: applyOp = (old & ~mask) | (wd & mask);
      OP_SET:   applyOp = old | (wd & mask);
      OP_CLEAR: applyOp = old & ~(wd & mask);
      default:  applyOp = old;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swPend <= '0;
      enReg  <= '0;
    end else begin
      if (strobe.pendLoad) swPend <= applyOp(swPend, csrWdata, strobe.pendMask, strobe.op);
      if (strobe.enLoad)   enReg  <= applyOp(enReg, csrWdata, strobe.enMask, strobe.op);
    end
  end

  always_comb begin
    mipView = (hwPend | swPend) & VALID_MASK;
    mieView = enReg;
    sipView = mipView & deleg;
    sieView = enReg & deleg;
    pendEn  = mipView & enReg;
    // privLvl[1] set means machine level (2'b10 folds into M)
    globalM = !privLvl[1] || gieM;
    globalS = (privLvl == 2'b00) || ((privLvl == 2'b01) && gieS);
    mElig   = globalM ? (pendEn & ~deleg) : '0;
    sElig   = globalS ? (pendEn & deleg) : '0;
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_deleg_pkg::*;
#(
  parameter int N  = NUM_IRQ,
  parameter int CW = CAUSE_W,
  parameter logic [N-1:0] VALID_MASK = IRQ_MASK,
  parameter logic [N-1:0] SWP_MASK   = SW_MASK,
  parameter logic [N-1:0] SUPP_MASK  = SSIP_MASK
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csrWe,
  input  logic [1:0]    csrSel,
  input  logic [1:0]    csrOp,
  input  logic [N-1:0]  deleg,
  input  logic          instrBoundary,
  input  logic [N-1:0]  mElig,
  input  logic [N-1:0]  sElig,
  output wrStrobe_t     strobe,
  output logic          takeIrq,
  output logic [1:0]    takeMode,
  output logic [CW-1:0] takeCause
);
  localparam int NPRIO = 6;
  localparam int PRIO [NPRIO] = '{11, 3, 7, 9, 1, 5};

  logic          anyM;
  logic          anyS;
  logic [N-1:0]  winSet;
  logic [CW-1:0] pick;

  always_comb begin
    strobe.op       = csrOp_e'(csrOp);
    strobe.pendLoad = csrWe && (csrSel == SEL_MIP || csrSel == SEL_SIP);
    strobe.enLoad   = csrWe && (csrSel == SEL_MIE || csrSel == SEL_SIE);
    strobe.pendMask = (csrSel == SEL_MIP) ? SWP_MASK : (SUPP_MASK & deleg);
    strobe.enMask   = (csrSel == SEL_MIE) ? VALID_MASK : (VALID_MASK & deleg);
  end

  always_comb begin
    anyM   = |mElig;
    anyS   = |sElig;
    winSet = anyM ? mElig : sElig;
    pick   = '0;
    // walk lowest rank first so the highest rank is assigned last
    for (int i = NPRIO - 1; i >= 0; i--) begin
      if (winSet[PRIO[i]]) pick = CW'(PRIO[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeIrq   <= 1'b0;
      takeMode  <= 2'b11;
      takeCause <= '0;
    end else begin
      takeIrq <= instrBoundary && (anyM || anyS);
      if (instrBoundary && (anyM || anyS)) begin
        takeMode  <= anyM ? 2'b11 : 2'b01;
        takeCause <= pick;
      end
    end
  end
endmodule

// File: rtl/irq_delegation_unit.sv
module irq_delegation_unit
  import irq_deleg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_IRQ-1:0]  hwPend,
  input  logic [NUM_IRQ-1:0]  deleg,
  input  logic [1:0]          privLvl,
  input  logic                gieM,
  input  logic                gieS,
  input  logic                instrBoundary,
  input  logic                csrWe,
  input  logic [1:0]          csrSel,
  input  logic [1:0]          csrOp,
  input  logic [NUM_IRQ-1:0]  csrWdata,
  output logic                takeIrq,
  output logic [1:0]          takeMode,
  output logic [CAUSE_W-1:0]  takeCause,
  output logic [NUM_IRQ-1:0]  mipView,
  output logic [NUM_IRQ-1:0]  mieView,
  output logic [NUM_IRQ-1:0]  sipView,
  output logic [NUM_IRQ-1:0]  sieView
);
  wrStrobe_t          strobe;
  logic [NUM_IRQ-1:0] mElig;
  logic [NUM_IRQ-1:0] sElig;

  irq_datapath #(.N(NUM_IRQ), .VALID_MASK(IRQ_MASK)) dp (
    .clk(clk), .rstN(rstN), .hwPend(hwPend), .deleg(deleg), .privLvl(privLvl),
    .gieM(gieM), .gieS(gieS), .csrWdata(csrWdata), .strobe(strobe),
    .mipView(mipView), .mieView(mieView), .sipView(sipView), .sieView(sieView),
    .mElig(mElig), .sElig(sElig)
  );

  irq_control #(.N(NUM_IRQ), .CW(CAUSE_W), .VALID_MASK(IRQ_MASK),
                .SWP_MASK(SW_MASK), .SUPP_MASK(SSIP_MASK)) ctl (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrSel(csrSel), .csrOp(csrOp),
    .deleg(deleg), .instrBoundary(instrBoundary), .mElig(mElig), .sElig(sElig),
    .strobe(strobe), .takeIrq(takeIrq), .takeMode(takeMode), .takeCause(takeCause)
  );
endmodule

// File: rtl/irq_deleg_checker.sv
module irq_deleg_checker
  import irq_deleg_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_IRQ-1:0] deleg,
  input logic [1:0]         privLvl,
  input logic               instrBoundary,
  input logic               csrWe,
  input logic               takeIrq,
  input logic [1:0]         takeMode,
  input logic [CAUSE_W-1:0] takeCause,
  input logic [NUM_IRQ-1:0] mipView,
  input logic [NUM_IRQ-1:0] mieView
);
  logic [NUM_IRQ-1:0] delegPrev;
  logic [NUM_IRQ-1:0] readyPrev;
  logic               inMPrev;

  always_ff @(posedge clk) begin
    delegPrev <= deleg;
    readyPrev <= mipView & mieView;
    inMPrev   <= privLvl[1];
  end

  // R5
  deleg_not_in_m_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> !(inMPrev && delegPrev[takeCause]));

  // R6
  m_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && takeMode == 2'b11) |-> !delegPrev[takeCause]);

  // R7
  s_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && takeMode == 2'b01) |-> delegPrev[takeCause]);

  // R9
  needs_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrBoundary |=> !takeIrq);

  // R8
  cause_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> readyPrev[takeCause]);

  // R10
  enable_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csrWe |=> $stable(mieView));
endmodule

bind irq_delegation_unit irq_deleg_checker chk (.*);

// File: tb/irq_delegation_unit_test.sv
`timescale 1ns/1ps
module irq_delegation_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] hwPend = '0, deleg = '0, csrWdata = '0;
  logic [1:0]  privLvl = 2'b11, csrSel = '0, csrOp = 2'd3;
  logic        gieM = 1'b0, gieS = 1'b0, instrBoundary = 1'b0, csrWe = 1'b0;
  logic        takeIrq;
  logic [1:0]  takeMode;
  logic [3:0]  takeCause;
  logic [11:0] mipView, mieView, sipView, sieView;

  int checks = 0, fails = 0;
  logic [11:0] mSw = '0, mEn = '0;
  logic [1:0]  lastMode = 2'b11;
  logic [3:0]  lastCause = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_delegation_unit uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] opModel(logic [11:0] old, logic [11:0] wd,
                                          logic [11:0] mask, logic [1:0] op);
    case (op)
      2'd0: return (old & ~mask) | (wd & mask);
      2'd1: return old | (wd & mask);
      2'd2: return old & ~(wd & mask);
      default: return old;
    endcase
  endfunction

  // Returns {valid, mode, cause}
  function automatic logic [6:0] expTake(logic [11:0] hw, logic [11:0] dl, logic [1:0] pv,
                                         logic gm, logic gs);
    int order [6] = '{11, 3, 7, 9, 1, 5};
    logic [11:0] pe = (hw | mSw) & mEn & 12'hAAA;
    logic [11:0] mset = pe & ~dl;
    logic [11:0] sset = pe & dl;
    logic mOk = (pv != 2'b11) || gm;
    logic sOk = (pv == 2'b00) || (pv == 2'b01 && gs);
    if (mOk && mset != 0)
      foreach (order[i]) if (mset[order[i]]) return {1'b1, 2'b11, 4'(order[i])};
    if (sOk && sset != 0)
      foreach (order[i]) if (sset[order[i]]) return {1'b1, 2'b01, 4'(order[i])};
    return 7'd0;
  endfunction

  task automatic cycle(logic [11:0] hw, logic [11:0] dl, logic [1:0] pv, logic gm, logic gs,
                       logic bnd, logic we, logic [1:0] sel, logic [1:0] op, logic [11:0] wd);
    logic [6:0] e;
    logic [11:0] mip;
    hwPend = hw; deleg = dl; privLvl = pv; gieM = gm; gieS = gs;
    instrBoundary = bnd; csrWe = we; csrSel = sel; csrOp = op; csrWdata = wd;
    #1;
    mip = (hw | mSw) & 12'hAAA;
    chk("R2 mip", mipView, mip);
    chk("R2 sip", sipView, mip & dl);
    chk("R10 mie", mieView, mEn);
    chk("R3 sie", sieView, mEn & dl);
    e = bnd ? expTake(hw, dl, pv, gm, gs) : 7'd0;
    if (we) begin
      case (sel)
        2'd0: mSw = opModel(mSw, wd, 12'h222, op);
        2'd1: mSw = opModel(mSw, wd, 12'h002 & dl, op);
        2'd2: mEn = opModel(mEn, wd, 12'hAAA, op);
        default: mEn = opModel(mEn, wd, 12'hAAA & dl, op);
      endcase
    end
    @(posedge clk); @(negedge clk);
    if (e[6]) begin lastMode = e[5:4]; lastCause = e[3:0]; end
    chk("R9 take", takeIrq, e[6]);
    chk(lastMode == 2'b01 ? "R7 mode" : "R6 mode", takeMode, lastMode);
    chk("R8 cause", takeCause, lastCause);
    csrWe = 1'b0; instrBoundary = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk("R1 take", takeIrq, 0);
    chk("R1 mode", takeMode, 2'b11);
    chk("R1 cause", takeCause, 0);
    chk("R1 mip", mipView, 0);
    chk("R1 mie", mieView, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 take after release", takeIrq, 0);

    // delegated supervisor timer in M-mode
    cycle(0, 12'h020, 2'b11, 1, 1, 0, 1, 2'd2, 2'd1, 12'h020);
    cycle(0, 12'h020, 2'b11, 1, 1, 0, 1, 2'd0, 2'd1, 12'h020);
    chk("R4 sti set", mipView, 12'h020);
    cycle(0, 12'h020, 2'b11, 1, 1, 1, 0, 0, 0, 0);
    chk("R5 no take in M", takeIrq, 0);
    cycle(0, 12'h020, 2'b01, 0, 1, 1, 0, 0, 0, 0);
    chk("R7 S take", {takeIrq, takeMode, takeCause}, {1'b1, 2'b01, 4'd5});
    cycle(0, 12'h020, 2'b01, 0, 0, 1, 0, 0, 0, 0);
    chk("R7 gieS off", takeIrq, 0);
    cycle(0, 12'h020, 2'b00, 0, 0, 1, 0, 0, 0, 0);
    chk("R7 U take", takeIrq, 1);
    cycle(0, 12'h000, 2'b11, 0, 0, 1, 0, 0, 0, 0);
    chk("R6 gieM off", takeIrq, 0);
    cycle(0, 12'h000, 2'b11, 1, 0, 1, 0, 0, 0, 0);
    chk("R6 M take", {takeIrq, takeMode, takeCause}, {1'b1, 2'b11, 4'd5});
    // ignored writes
    cycle(0, 12'h020, 2'b11, 0, 0, 0, 1, 2'd1, 2'd1, 12'h002);
    chk("R4 sip write undelegated", mipView & 12'h002, 0);
    cycle(0, 12'h020, 2'b11, 0, 0, 0, 1, 2'd0, 2'd3, 12'hFFF);
    chk("R4 op none", mipView, 12'h020);
    cycle(0, 12'h020, 2'b11, 0, 0, 0, 1, 2'd2, 2'd0, 12'hFFF);
    chk("R10 mie masked", mieView, 12'hAAA);
    cycle(0, 12'h020, 2'b11, 0, 0, 0, 1, 2'd3, 2'd2, 12'hFFF);
    chk("R3 sie clear delegated only", mieView, 12'hA8A);
    // priority: M-target beats S-target, order among M
    cycle(12'h888, 12'h800, 2'b01, 0, 1, 1, 0, 0, 0, 0);
    chk("R8 M over S", {takeMode, takeCause}, {2'b11, 4'd3});

    for (int k = 0; k < 3000; k++) begin
      logic [1:0] pv;
      case ($urandom_range(2)) 0: pv = 2'b00; 1: pv = 2'b01; default: pv = 2'b11; endcase
      cycle(12'($urandom & $urandom), 12'($urandom), pv, 1'($urandom), 1'($urandom),
            1'($urandom), ($urandom_range(3) == 0), 2'($urandom), 2'($urandom), 12'($urandom));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule